// File: doc/BRIEF.md
# USB Endpoint Status and Control Flags

This block holds the flags and small control fields that sit between a low-speed USB serial engine and the firmware driving it. The engine reports single-cycle event pulses:

- a valid SETUP token
- an OUT token that carries data
- a zero-length OUT packet
- a FIFO access error
- a completed IN transfer
- a FIFO read

Each event sets or clears one of four sticky flags. Firmware sees those flags, a staging address and the active device address through a byte-wide register port. It can clear the flags that it owns.

The active device address is loaded from the staging register under one of two policies. In the immediate policy it loads at once when the staging register is written. In the deferred policy it loads only when the host completes an IN read. The deferred policy suits a status stage that must still answer at the old address.

Firmware can also ask for the endpoint FIFO to be flushed. The block then emits a one-cycle flush pulse and arms an underrun marker. The marker makes the next host IN request return a forced transmit error.

All pins are plain control or status pins. No data stream crosses the block, so there is no valid/ready handshake. Events are single-cycle pulses and are never back-pressured.

Top module: `usb_epf_regs`

Register map, with the 2-bit address on `wr_addr` and `rd_addr`:

| Addr | Register | Bits |
|---|---|---|
| 0 | STATUS | bit2 = OUT flag, bit1 = ERR flag, bit0 = address mode (0 immediate, 1 deferred), bits 7:3 read 0 |
| 1 | STAGE | bits 6:0 = staging address, bit7 reads 0 |
| 2 | MISC | bit7 = LEN0, bit6 = FIFO ready, bit5 = SETCMD, bits 4:3 read 0, bit2 = flush request (reads 0), bit1 = TX control, bit0 = REQUEST control |
| 3 | ACTIVE | bits 6:0 = active device address (read-only), bit7 reads 0 |

Writes follow these rules:

- Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged.
- The mode, TX and REQUEST bits store the written value.

## Requirements
- R1: After reset, every flag, the mode bit, TX, REQUEST, the staging address and the active address read 0. `fifo_flush` and `force_tx_err` are low.
- R2: `ev_out` sets the OUT flag (STATUS bit2) and `ev_out_zlp` does not. The flag is cleared by a STATUS write with bit2 = 0 or by `ev_setup`. A STATUS write with bit2 = 1 leaves it unchanged.
- R3: `ev_fifo_err` sets the ERR flag (STATUS bit1). Only a STATUS write with bit1 = 0 clears it; `ev_setup` and the other events leave it unchanged.
- R4: `ev_out_zlp` sets LEN0 (MISC bit7) and `ev_fifo_rd` clears it. Firmware writes to MISC leave it unchanged.
- R5: `ev_setup` sets SETCMD (MISC bit5). Only a MISC write with bit5 = 0 clears it.
- R6: When an event that sets a flag and a clear of that same flag fall in the same cycle, the flag ends up set.
- R7: With mode = 0, writing STAGE makes `dev_addr` and ACTIVE equal to the written bits 6:0 from the next cycle on. `ev_in_ok` has no effect in this mode.
- R8: With mode = 1, writing STAGE leaves `dev_addr` unchanged. Each `ev_in_ok` loads the staging address into `dev_addr` for the next cycle.
- R9: A MISC write with bit2 = 1 makes `fifo_flush` high for exactly the next cycle and arms the underrun marker. MISC bit2 always reads 0.
- R10: While the marker is armed, `force_tx_err` follows `in_req` in the same cycle. The first `in_req` disarms the marker, so a later `in_req` gets no error until the next flush request.
- R11: MISC bit6 reflects `fifo_ready`, MISC bits 1:0 read back the stored TX and REQUEST values, and MISC bits 4:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_setup | input | 1 | Valid SETUP token pulse |
| ev_out | input | 1 | OUT token with data pulse |
| ev_out_zlp | input | 1 | Zero-length OUT pulse |
| ev_fifo_err | input | 1 | FIFO access error pulse |
| ev_fifo_rd | input | 1 | FIFO read pulse |
| ev_in_ok | input | 1 | Host completed IN read pulse |
| in_req | input | 1 | Host IN request being answered this cycle |
| fifo_ready | input | 1 | FIFO ready level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| dev_addr | output | 7 | Active device address |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| force_tx_err | output | 1 | Forced transmit error for the current IN request |

## Verification
The hardest cases to reach are the collisions. One is a hardware set and a firmware clear of the same flag in one cycle. Another is an `ev_in_ok` that lands while the deferred policy holds a staging value different from the active one. The bench drives event pulses and register writes in the same cycle and sweeps every combination of prior flag state, set event and clear source. It also walks all 128 staging addresses under both policies, checking `dev_addr` before and after each IN completion.

// File: rtl/usb_epf_pkg.sv
`timescale 1ns/1ps
package usb_epf_pkg;
  localparam int DW = 8;
  localparam int RAW = 2;

  localparam logic [RAW-1:0] RA_STATUS = 2'd0;
  localparam logic [RAW-1:0] RA_STAGE  = 2'd1;
  localparam logic [RAW-1:0] RA_MISC   = 2'd2;
  localparam logic [RAW-1:0] RA_ACTIVE = 2'd3;

  // STATUS bit positions
  localparam int SB_MODE = 0;
  localparam int SB_ERR  = 1;
  localparam int SB_OUT  = 2;
  // MISC bit positions
  localparam int MB_REQ    = 0;
  localparam int MB_TX     = 1;
  localparam int MB_FLUSH  = 2;
  localparam int MB_SETCMD = 5;
  localparam int MB_READY  = 6;
  localparam int MB_LEN0   = 7;

  // sticky flag indices
  localparam int NFLAG    = 4;
  localparam int F_OUT    = 0;
  localparam int F_ERR    = 1;
  localparam int F_LEN0   = 2;
  localparam int F_SETCMD = 3;
endpackage

// File: rtl/usb_epf_flag.sv
`timescale 1ns/1ps
module usb_epf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r6_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/usb_epf_addr.sv
`timescale 1ns/1ps
module usb_epf_addr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_we_i,
  input  logic [AW-1:0] stage_wdata_i,
  input  logic          mode_i,
  input  logic          in_ok_i,
  output logic [AW-1:0] stage_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] stage_d;
  logic          commit;

  assign stage_d = stage_we_i ? stage_wdata_i : stage_o;
  assign commit  = mode_i ? in_ok_i : stage_we_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_o <= '0;
      addr_o  <= '0;
    end else begin
      stage_o <= stage_d;
      if (commit) addr_o <= stage_d;
    end
  end

  a_r7_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_we_i && !mode_i) |=> addr_o == $past(stage_wdata_i));
  a_r8_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !in_ok_i) |=> $stable(addr_o));
  a_r8_deferred_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && in_ok_i && !stage_we_i) |=> addr_o == $past(stage_o));
endmodule

// File: rtl/usb_epf_underrun.sv
`timescale 1ns/1ps
module usb_epf_underrun (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_req_i,
  input  logic in_req_i,
  output logic flush_o,
  output logic armed_o,
  output logic force_err_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_o <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      flush_o <= flush_req_i;
      if (flush_req_i)   armed_o <= 1'b1;
      else if (in_req_i) armed_o <= 1'b0;
    end
  end

  assign force_err_o = armed_o & in_req_i;

  a_r9_flush_arms: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_i |=> (flush_o && armed_o));
  a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req_i |=> !flush_o);
  a_r10_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && in_req_i && !flush_req_i) |=> !armed_o);
endmodule

// File: rtl/usb_epf_regs.sv
`timescale 1ns/1ps
module usb_epf_regs
  import usb_epf_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_setup,
  input  logic           ev_out,
  input  logic           ev_out_zlp,
  input  logic           ev_fifo_err,
  input  logic           ev_fifo_rd,
  input  logic           ev_in_ok,
  input  logic           in_req,
  input  logic           fifo_ready,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [AW-1:0]  dev_addr,
  output logic           fifo_flush,
  output logic           force_tx_err
);
  localparam int PAD = DW - AW;

  logic wr_status, wr_stage, wr_misc;
  logic mode_q, tx_q, req_q;
  logic armed;
  logic [AW-1:0] stage_q;
  logic [NFLAG-1:0] fset, fclr, fq;
  logic unused_wdata;

  assign wr_status = wr_en && (wr_addr == RA_STATUS);
  assign wr_stage  = wr_en && (wr_addr == RA_STAGE);
  assign wr_misc   = wr_en && (wr_addr == RA_MISC);
  assign unused_wdata = &{1'b0, wr_data[4:3], wr_data[DW-1:AW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      tx_q   <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (wr_status) mode_q <= wr_data[SB_MODE];
      if (wr_misc) begin
        tx_q  <= wr_data[MB_TX];
        req_q <= wr_data[MB_REQ];
      end
    end
  end

  // per-flag set and clear sources
  always_comb begin
    fset = '0;
    fclr = '0;
    fset[F_OUT]    = ev_out;
    fclr[F_OUT]    = ev_setup | (wr_status & ~wr_data[SB_OUT]);
    fset[F_ERR]    = ev_fifo_err;
    fclr[F_ERR]    = wr_status & ~wr_data[SB_ERR];
    fset[F_LEN0]   = ev_out_zlp;
    fclr[F_LEN0]   = ev_fifo_rd;
    fset[F_SETCMD] = ev_setup;
    fclr[F_SETCMD] = wr_misc & ~wr_data[MB_SETCMD];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    usb_epf_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fset[g]),
      .clr_i (fclr[g]),
      .q_o   (fq[g])
    );
  end

  usb_epf_addr #(.AW(AW)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .stage_we_i    (wr_stage),
    .stage_wdata_i (wr_data[AW-1:0]),
    .mode_i        (mode_q),
    .in_ok_i       (ev_in_ok),
    .stage_o       (stage_q),
    .addr_o        (dev_addr)
  );

  usb_epf_underrun u_urun (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_req_i (wr_misc & wr_data[MB_FLUSH]),
    .in_req_i    (in_req),
    .flush_o     (fifo_flush),
    .armed_o     (armed),
    .force_err_o (force_tx_err)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_STATUS: begin
        rd_data[SB_OUT]  = fq[F_OUT];
        rd_data[SB_ERR]  = fq[F_ERR];
        rd_data[SB_MODE] = mode_q;
      end
      RA_STAGE:  rd_data = {{PAD{1'b0}}, stage_q};
      RA_MISC: begin
        rd_data[MB_LEN0]   = fq[F_LEN0];
        rd_data[MB_READY]  = fifo_ready;
        rd_data[MB_SETCMD] = fq[F_SETCMD];
        rd_data[MB_TX]     = tx_q;
        rd_data[MB_REQ]    = req_q;
      end
      default:   rd_data = {{PAD{1'b0}}, dev_addr};
    endcase
  end

  a_r2_setup_clears_out: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_setup && !ev_out) |=> !fq[F_OUT]);
  a_r3_err_fw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_status && !ev_fifo_err) |=> $stable(fq[F_ERR]));
  a_r4_len0_fw_immune: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_out_zlp && !ev_fifo_rd) |=> $stable(fq[F_LEN0]));
  a_r10_err_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !in_req |-> !force_tx_err);
endmodule

// File: tb/tb_usb_epf_regs.sv
`timescale 1ns/1ps
module tb_usb_epf_regs;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_setup, ev_out, ev_out_zlp, ev_fifo_err, ev_fifo_rd, ev_in_ok;
  logic in_req, fifo_ready, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [6:0] dev_addr;
  logic fifo_flush, force_tx_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_epf_regs dut (
    .clk(clk), .rst_n(rst_n), .ev_setup(ev_setup), .ev_out(ev_out),
    .ev_out_zlp(ev_out_zlp), .ev_fifo_err(ev_fifo_err), .ev_fifo_rd(ev_fifo_rd),
    .ev_in_ok(ev_in_ok), .in_req(in_req), .fifo_ready(fifo_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .dev_addr(dev_addr), .fifo_flush(fifo_flush),
    .force_tx_err(force_tx_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_setup = 0; ev_out = 0; ev_out_zlp = 0; ev_fifo_err = 0;
    ev_fifo_rd = 0; ev_in_ok = 0; in_req = 0; wr_en = 0;
    wr_addr = 0; wr_data = 0;
  endtask

  // one clock with the currently driven inputs, then return to idle
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic fw_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [6:0] prev;
    idle();
    rd_addr = 0; fifo_ready = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check($sformatf("R1 reg%0d", a), v, 0);
    end
    check("R1 dev_addr", dev_addr, 0);
    check("R1 fifo_flush", fifo_flush, 0);
    in_req = 1; #1;
    check("R1 force_tx_err", force_tx_err, 0);
    tick();

    // R2 OUT flag: zlp does not set, ev_out sets, write 1 keeps, setup clears
    ev_out_zlp = 1; tick();
    rd(0, v); check("R2 zlp no OUT", v[2], 0);
    ev_out = 1; tick();
    rd(0, v); check("R2 ev_out sets", v[2], 1);
    fw_wr(0, 8'h06);
    rd(0, v); check("R2 write1 keeps", v[2], 1);
    ev_setup = 1; tick();
    rd(0, v); check("R2 setup clears", v[2], 0);

    // R2/R6 sweep: prior state x set x clear source (0 none, 1 fw write0, 2 setup)
    for (int s = 0; s < 12; s++) begin
      bit init, st;
      int src;
      init = s[0]; st = s[1]; src = s / 4;
      fw_wr(0, 8'h02);               // clear OUT, keep ERR bit written as 1
      if (init) begin ev_out = 1; tick(); end
      ev_out = st;
      if (src == 1) begin wr_en = 1; wr_addr = 0; wr_data = 8'h02; end
      if (src == 2) ev_setup = 1;
      tick();
      rd(0, v);
      check($sformatf("R6 OUT init%0d set%0d src%0d", init, st, src), v[2],
            (st || (init && src == 0)) ? 1 : 0);
    end

    // R3 ERR
    ev_fifo_err = 1; tick();
    rd(0, v); check("R3 err sets", v[1], 1);
    ev_setup = 1; tick();
    ev_fifo_rd = 1; ev_out = 1; tick();
    rd(0, v); check("R3 events keep err", v[1], 1);
    fw_wr(0, 8'h04);
    rd(0, v); check("R3 fw clears err", v[1], 0);
    ev_fifo_err = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h00; tick();
    rd(0, v); check("R6 err set beats clear", v[1], 1);
    fw_wr(0, 8'h00);

    // R4 LEN0
    ev_out_zlp = 1; tick();
    rd(2, v); check("R4 len0 sets", v[7], 1);
    fw_wr(2, 8'h00);
    rd(2, v); check("R4 fw write keeps len0", v[7], 1);
    ev_fifo_rd = 1; tick();
    rd(2, v); check("R4 fifo read clears len0", v[7], 0);
    ev_out_zlp = 1; tick();
    ev_out_zlp = 1; ev_fifo_rd = 1; tick();
    rd(2, v); check("R6 len0 set beats read", v[7], 1);
    ev_fifo_rd = 1; tick();

    // R5 SETCMD
    ev_setup = 1; tick();
    rd(2, v); check("R5 setcmd sets", v[5], 1);
    ev_fifo_rd = 1; ev_in_ok = 1; tick();
    fw_wr(2, 8'h20);
    rd(2, v); check("R5 write1 keeps setcmd", v[5], 1);
    fw_wr(2, 8'h00);
    rd(2, v); check("R5 write0 clears setcmd", v[5], 0);
    ev_setup = 1; wr_en = 1; wr_addr = 2; wr_data = 8'h00; tick();
    rd(2, v); check("R6 setcmd set beats clear", v[5], 1);
    fw_wr(2, 8'h00);

    // R7 immediate mode, all staging addresses
    for (int i = 0; i < 128; i++) begin
      fw_wr(1, 8'(i));
      check($sformatf("R7 dev_addr %0d", i), dev_addr, i);
    end
    rd(3, v); check("R7 active readback", v, 127);
    fw_wr(1, 8'h15);
    ev_in_ok = 1; tick();
    check("R7 in_ok ignored", dev_addr, 8'h15);

    // R8 deferred mode
    fw_wr(0, 8'h01);
    rd(0, v); check("R8 mode bit", v[0], 1);
    prev = dev_addr;
    for (int i = 0; i < 128; i++) begin
      int a;
      a = (i * 37 + 5) % 128;
      fw_wr(1, 8'(a));
      rd(1, v); check("R8 stage readback", v, a);
      check($sformatf("R8 held before IN %0d", a), dev_addr, prev);
      ev_in_ok = 1; tick();
      check($sformatf("R8 commit on IN %0d", a), dev_addr, a);
      prev = 7'(a);
    end
    fw_wr(0, 8'h00);
    fw_wr(1, 8'h33);
    check("R7 back to immediate", dev_addr, 8'h33);

    // R9/R10 flush and underrun
    in_req = 1; #1;
    check("R10 no error unarmed", force_tx_err, 0);
    tick();
    fw_wr(2, 8'h04);
    check("R9 flush pulse", fifo_flush, 1);
    rd(2, v); check("R9 flush bit reads 0", v[2], 0);
    #1; check("R10 no error without request", force_tx_err, 0);
    tick();
    check("R9 flush one cycle", fifo_flush, 0);
    in_req = 1; #1;
    check("R10 error on first IN", force_tx_err, 1);
    tick();
    in_req = 1; #1;
    check("R10 no error on second IN", force_tx_err, 0);
    tick();
    fw_wr(2, 8'h04);
    in_req = 1; #1;
    check("R10 rearmed", force_tx_err, 1);
    tick();

    // R11 misc fields
    fifo_ready = 1;
    fw_wr(2, 8'hFB);
    rd(2, v);
    check("R11 ready bit", v[6], 1);
    check("R11 tx/req readback", v[1:0], 3);
    check("R11 gap bits zero", v[4:3], 0);
    fifo_ready = 0;
    fw_wr(2, 8'h01);
    rd(2, v);
    check("R11 ready low", v[6], 0);
    check("R11 tx/req second", v[1:0], 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule